// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-node bookkeeping engine for a small cache-coherent system built around a point-to-point network. For each memory block it keeps a record of which processor caches hold a copy, with one presence bit per cache, plus a flag that marks a single cache as the exclusive holder. Caches send it read-miss and write-miss requests. The controller decides which other caches must give up their copies. It sends each of them a targeted message, collects their acknowledgements and only then answers the requester.

Requests arrive on a valid/ready port. Outgoing traffic leaves on one message port, one message per cycle. Each message has a kind, a destination cache, the identity of the original requester and the block number. Acknowledgements come back on a separate one-cycle strobe that carries the identity of the acknowledging cache. The controller works on one transaction at a time. While a transaction is open, `req_ready` stays low, so a request to any block, including a busy one, is held off.

Message kind encoding on `msg_kind`: 0 = invalidate, 1 = recall of an exclusive copy, 2 = read reply, 3 = write reply.

Top module: `dirc_home_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `msg_valid` is 0, and every block has no sharers and is not exclusive.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 until the cycle after the reply message. No message is issued while `req_ready` is 1.
- R3: A write request to a block sends an invalidate (kind 0) to every cache whose presence bit is set, except the requester. Invalidates go out one per cycle in ascending cache index, and each carries the requester identity in `msg_req`.
- R4: The write reply (kind 3) is issued only after an acknowledgement has arrived from every cache that was sent an invalidate or recall.
- R5: When a write completes, only the writer's presence bit is set and the block is exclusive. A later read by another cache therefore recalls only the writer.
- R6: A read to a block that is not exclusive adds the requester to the sharers and answers with a read reply (kind 2), without invalidating anyone.
- R7: A read to a block held exclusive by a different cache first sends a recall (kind 1) to the owner and waits for its acknowledgement. It then answers with a read reply, leaving both caches present and the block not exclusive.
- R8: A write by a cache that is already the only holder, and a read by the exclusive owner, produce just the reply with no invalidate or recall.
- R9: Every reply goes to the requester (`msg_dst` equals `msg_req`), and every message carries the requested block number in `msg_blk`.
- R10: Directory state is kept separately for each block. A request to one block never changes the sharers of another block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_src | input | IDW | Requesting cache |
| req_blk | input | BW | Requested block |
| ack_valid | input | 1 | Acknowledgement strobe from a cache |
| ack_src | input | IDW | Cache sending the acknowledgement |
| msg_valid | output | 1 | Outgoing message present (network always accepts) |
| msg_kind | output | 2 | 0 invalidate, 1 recall, 2 read reply, 3 write reply |
| msg_dst | output | IDW | Destination cache |
| msg_req | output | IDW | Requester of the current transaction |
| msg_blk | output | BW | Block of the current transaction |

## Verification
The assertions take for granted that caches acknowledge only messages they were actually sent, at most once each, and never while the controller is idle. They also assume that the network accepts every message in the cycle it is issued. The bench keeps to this with a responder that acknowledges only after it sees an invalidate or recall addressed to a cache. Acknowledgements are sent one at a time with varying delays of zero to two cycles. Requests are held on the port until they are taken, so back-pressure is exercised without any request being dropped.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [1:0] {
    MK_INV   = 2'd0,
    MK_RECALL = 2'd1,
    MK_RDREP = 2'd2,
    MK_WRREP = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_REPLY
  } dir_state_e;
endpackage

// File: rtl/dirc_pick.sv
// Lowest-index set bit of a mask, as index and one-hot.
module dirc_pick #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic [N-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
    onehot = (|vec) ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/dirc_store.sv
// Per-block presence vector and exclusive flag.
module dirc_store #(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int BW    = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_blk,
  output logic [NPROC-1:0] rd_pres,
  output logic             rd_excl,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_blk,
  input  logic [NPROC-1:0] wr_pres,
  input  logic             wr_excl
);
  logic [NPROC-1:0] pres_r [NBLK];
  logic             excl_r [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_blk == BW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_r[b] <= '0;
        excl_r[b] <= 1'b0;
      end else if (hit) begin
        pres_r[b] <= wr_pres;
        excl_r[b] <= wr_excl;
      end
    end
  end

  assign rd_pres = pres_r[rd_blk];
  assign rd_excl = excl_r[rd_blk];
endmodule

// File: rtl/dirc_txn_fsm.sv
// One-transaction-at-a-time sequencer: invalidate/recall, collect acks, reply.
module dirc_txn_fsm
  import dirc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int IDW   = $clog2(NPROC),
  parameter int BW    = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IDW-1:0]   req_src,
  input  logic [BW-1:0]    req_blk,
  input  logic             ack_valid,
  input  logic [IDW-1:0]   ack_src,
  input  logic [NPROC-1:0] rd_pres,
  input  logic             rd_excl,
  output logic             dir_we,
  output logic [BW-1:0]    dir_blk,
  output logic [NPROC-1:0] dir_pres,
  output logic             dir_excl,
  output logic             msg_valid,
  output msg_kind_e        msg_kind,
  output logic [IDW-1:0]   msg_dst,
  output logic [IDW-1:0]   msg_req,
  output logic [BW-1:0]    msg_blk
);
  dir_state_e       state_q, state_d;
  logic [NPROC-1:0] pend_q, pend_d, wait_q, wait_d;
  logic [NPROC-1:0] pres_q, req_oh, src_oh, ack_oh, tgt_init, pick_oh;
  logic [IDW-1:0]   src_q, pick_idx;
  logic [BW-1:0]    blk_q;
  logic             wr_q, excl_q, load;

  assign req_oh = NPROC'(1) << req_src;
  assign src_oh = NPROC'(1) << src_q;
  assign ack_oh = ack_valid ? (NPROC'(1) << ack_src) : '0;

  // Caches that must give up their copy before the reply
  always_comb begin
    if (req_write)
      tgt_init = rd_pres & ~req_oh;
    else if (rd_excl && !(|(rd_pres & req_oh)))
      tgt_init = rd_pres;
    else
      tgt_init = '0;
  end

  dirc_pick #(.N(NPROC), .W(IDW)) u_pick (
    .vec(pend_q), .idx(pick_idx), .onehot(pick_oh)
  );

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    wait_d    = wait_q & ~ack_oh;
    load      = 1'b0;
    req_ready = 1'b0;
    msg_valid = 1'b0;
    msg_kind  = MK_INV;
    msg_dst   = src_q;
    dir_we    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          load    = 1'b1;
          pend_d  = tgt_init;
          wait_d  = '0;
          state_d = (|tgt_init) ? ST_ISSUE : ST_REPLY;
        end
      end
      ST_ISSUE: begin
        msg_valid = 1'b1;
        msg_kind  = wr_q ? MK_INV : MK_RECALL;
        msg_dst   = pick_idx;
        pend_d    = pend_q & ~pick_oh;
        wait_d    = (wait_q | pick_oh) & ~ack_oh;
        if (pend_d == '0) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (wait_q == '0) state_d = ST_REPLY;
      end
      ST_REPLY: begin
        msg_valid = 1'b1;
        msg_kind  = wr_q ? MK_WRREP : MK_RDREP;
        dir_we    = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      wait_q  <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      blk_q  <= '0;
      wr_q   <= 1'b0;
      pres_q <= '0;
      excl_q <= 1'b0;
    end else if (load) begin
      src_q  <= req_src;
      blk_q  <= req_blk;
      wr_q   <= req_write;
      pres_q <= rd_pres;
      excl_q <= rd_excl;
    end
  end

  assign dir_blk  = blk_q;
  assign dir_pres = wr_q ? src_oh : (pres_q | src_oh);
  assign dir_excl = wr_q | (excl_q && (pres_q == src_oh));
  assign msg_req  = src_q;
  assign msg_blk  = blk_q;
endmodule

// File: rtl/dirc_home_ctrl.sv
module dirc_home_ctrl
  import dirc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int IDW   = $clog2(NPROC),
  parameter int BW    = $clog2(NBLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [IDW-1:0] req_src,
  input  logic [BW-1:0]  req_blk,
  input  logic           ack_valid,
  input  logic [IDW-1:0] ack_src,
  output logic           msg_valid,
  output logic [1:0]     msg_kind,
  output logic [IDW-1:0] msg_dst,
  output logic [IDW-1:0] msg_req,
  output logic [BW-1:0]  msg_blk
);
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NPROC-1:0] rd_pres, dir_pres;
  logic             rd_excl, dir_we, dir_excl;
  logic [BW-1:0]    dir_blk;
  msg_kind_e        kind;

  dirc_store #(.NPROC(NPROC), .NBLK(NBLK), .BW(BW)) u_store (
    .clk(clk), .rst_n(rst_sync),
    .rd_blk(req_blk), .rd_pres(rd_pres), .rd_excl(rd_excl),
    .wr_en(dir_we), .wr_blk(dir_blk), .wr_pres(dir_pres), .wr_excl(dir_excl)
  );

  dirc_txn_fsm #(.NPROC(NPROC), .NBLK(NBLK), .IDW(IDW), .BW(BW)) u_fsm (
    .clk(clk), .rst_n(rst_sync),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_src(req_src), .req_blk(req_blk),
    .ack_valid(ack_valid), .ack_src(ack_src),
    .rd_pres(rd_pres), .rd_excl(rd_excl),
    .dir_we(dir_we), .dir_blk(dir_blk), .dir_pres(dir_pres), .dir_excl(dir_excl),
    .msg_valid(msg_valid), .msg_kind(kind), .msg_dst(msg_dst),
    .msg_req(msg_req), .msg_blk(msg_blk)
  );

  assign msg_kind = kind;
endmodule

// File: rtl/dirc_home_chk.sv
module dirc_home_chk #(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int IDW   = $clog2(NPROC),
  parameter int BW    = $clog2(NBLK)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_write,
  input logic [IDW-1:0] req_src,
  input logic [BW-1:0]  req_blk,
  input logic           ack_valid,
  input logic [IDW-1:0] ack_src,
  input logic           msg_valid,
  input logic [1:0]     msg_kind,
  input logic [IDW-1:0] msg_dst,
  input logic [IDW-1:0] msg_req,
  input logic [BW-1:0]  msg_blk
);
  logic [7:0] outst;
  logic       sent;
  assign sent = msg_valid && (msg_kind < 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else if (sent && !ack_valid) outst <= outst + 8'd1;
    else if (!sent && ack_valid) outst <= outst - 8'd1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !msg_valid);

  a_r3_inv_not_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'd0) |-> (msg_dst != msg_req));

  a_r4_reply_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'd3) |-> (outst == 8'd0));

  a_r9_reply_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind >= 2'd2) |-> (msg_dst == msg_req));

  a_r9_blk_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(msg_blk));
endmodule

bind dirc_home_ctrl dirc_home_chk #(.NPROC(NPROC), .NBLK(NBLK), .IDW(IDW), .BW(BW)) u_chk (.*);

// File: tb/dirc_home_ctrl_tb.sv
module dirc_home_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPROC = 4;
  localparam int NBLK  = 8;
  localparam int IDW   = 2;
  localparam int BW    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [IDW-1:0] req_src;
  logic [BW-1:0]  req_blk;
  logic ack_valid;
  logic [IDW-1:0] ack_src;
  logic msg_valid;
  logic [1:0] msg_kind;
  logic [IDW-1:0] msg_dst, msg_req;
  logic [BW-1:0] msg_blk;

  dirc_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int mpres [NBLK];
  bit mexcl [NBLK];
  logic [15:0] expq [$];
  string tagq [$];
  int ackq [$];
  bit txn_open = 0, live = 0;
  int inv_seen = 0, acks_done = 0, ack_wait = 0, ack_ctr = 0, cyc = 0;

  function automatic logic [15:0] enc(int k, int d, int r, int b);
    return {k[3:0], d[3:0], r[3:0], b[3:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: expected message stream and directory per request
  task automatic send(bit w, int src, int blk, string tag);
    int so = 1 << src;
    if (w) begin
      for (int p = 0; p < NPROC; p++)
        if (((mpres[blk] & ~so) >> p) & 1) begin
          expq.push_back(enc(0, p, src, blk)); tagq.push_back(tag);
        end
      expq.push_back(enc(3, src, src, blk)); tagq.push_back(tag);
      mpres[blk] = so; mexcl[blk] = 1;
    end else begin
      if (mexcl[blk] && (mpres[blk] & so) == 0) begin
        for (int p = 0; p < NPROC; p++)
          if ((mpres[blk] >> p) & 1) begin
            expq.push_back(enc(1, p, src, blk)); tagq.push_back(tag);
          end
        mexcl[blk] = 0;
      end
      mpres[blk] |= so;
      expq.push_back(enc(2, src, src, blk)); tagq.push_back(tag);
    end
    req_valid = 1; req_write = w; req_src = IDW'(src); req_blk = BW'(blk);
    begin
      bit r;
      do begin @(negedge clk); r = req_ready; @(posedge clk); end while (!r);
    end
    #1;
    req_valid = 0;
    txn_open = 1;
  endtask

  // Acknowledgement responder with varying delay
  always @(posedge clk) begin
    #2;
    if (ack_valid) begin ack_valid = 0; acks_done++; end
    if (ack_wait > 0) ack_wait--;
    else if (ackq.size() > 0) begin
      ack_src = IDW'(ackq.pop_front());
      ack_valid = 1;
      ack_wait = ack_ctr % 3;
      ack_ctr++;
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    cyc++;
    if (live) begin
      chk(req_ready == !txn_open, "R2 ready", req_ready, !txn_open);
      if (msg_valid) begin
        logic [15:0] got;
        got = enc(msg_kind, msg_dst, msg_req, msg_blk);
        if (expq.size() == 0) chk(0, "R2 unexpected message", got, 0);
        else begin
          logic [15:0] e;
          string t;
          e = expq.pop_front(); t = tagq.pop_front();
          chk(got == e, t, got, e);
        end
        if (msg_kind < 2) begin ackq.push_back(msg_dst); inv_seen++; end
        else begin
          chk(acks_done == inv_seen, "R4 acks before reply", acks_done, inv_seen);
          inv_seen = 0; acks_done = 0; txn_open = 0;
        end
      end
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NBLK; b++) begin mpres[b] = 0; mexcl[b] = 0; end
    rst_n = 0; req_valid = 0; req_write = 0; req_src = '0; req_blk = '0;
    ack_valid = 0; ack_src = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(msg_valid == 1'b0, "R1 no message after reset", msg_valid, 0);
    @(posedge clk); #1 live = 1;

    send(1, 2, 4, "R1 fresh write no inv");        // empty block: reply only
    send(0, 0, 1, "R6 read adds sharer");
    send(0, 2, 1, "R6 read adds sharer");
    send(0, 3, 1, "R6 read adds sharer");
    send(1, 2, 1, "R3 inv ascending");             // INV 0, INV 3
    send(0, 1, 1, "R5 recall writer only");         // RECALL 2
    send(1, 3, 1, "R7 both present after recall");  // INV 1, INV 2
    send(1, 3, 1, "R8 owner write");
    send(0, 3, 1, "R8 owner read");
    send(0, 1, 5, "R10 other block");
    send(1, 0, 5, "R10 only own sharers");          // INV 1 only
    send(0, 2, 1, "R7 recall owner");               // RECALL 3
    send(1, 1, 7, "R9 block field");
    for (int it = 0; it < 6; it++) begin
      for (int p = 0; p < NPROC; p++) send(0, p, it % NBLK, "R6 sweep read");
      send(1, it % NPROC, it % NBLK, "R3 sweep write");
      send(0, (it + 1) % NPROC, it % NBLK, "R7 sweep recall");
    end

    begin
      int n = 0;
      while ((expq.size() != 0 || txn_open) && n < 1000) begin @(posedge clk); n++; end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R4 all replies seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule